// File: doc/BRIEF.md
# ATA Command Strobe Timing Generator

This block drives the read and write command strobes of one ATA channel that carries up to two drives. Each drive owns a 16-bit timing word. The word gives the length of the active phase, the length of the recovery phase and a flag that enables IORDY flow control. Both lengths are counted in clock periods. At the intended 30 ns clock, each count is the nanosecond requirement divided by 30 and rounded up. Both fields use a minus-one encoding, so a field value of zero gives one clock.

A host controller first loads the timing words through a small write port. It then issues accesses with a direction and a drive select. The block accepts an access only while `ready` is high. It raises the matching strobe for the programmed active length and keeps it raised while an IORDY-enabled device pulls IORDY low. It then holds the channel in recovery and signals completion with a one-cycle `done` at the moment `ready` returns.

The timing word is captured when an access is accepted. A rewrite of a word therefore never alters an access that is already running. As examples, the multiword DMA words 0x0707, 0x0201 and 0x0200 give 8/8, 3/2 and 3/1 clocks of active/recovery.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset both strobes and `done` are low and `ready` is high. Both timing words reset to 0xFFFF, which gives 16 active clocks, 64 recovery clocks and IORDY enabled.
- R2: An access is accepted on a clock edge where `ready` and `req_valid` are both high. From the next cycle the strobe for the chosen direction (`req_write`=1 selects `wr_strobe`, 0 selects `rd_strobe`) is high for (word[11:8] + 1) cycles.
- R3: After the strobe falls, `ready` stays low for (word[5:0] + 1) cycles. `ready` then rises, and `done` is high for exactly that first ready cycle.
- R4: When word bit 6 is set, IORDY is sampled at the last active cycle. While IORDY is low the strobe stays high, and it falls on the cycle after the edge at which IORDY is seen high.
- R5: When word bit 6 is clear, the IORDY input has no effect on the strobe length.
- R6: `req_drive` selects which drive's word times the access. `cfg_drive` selects which word a write with `cfg_we` loads.
- R7: Word bits 7 and [15:12] have no effect on timing.
- R8: A word write takes effect only at the next accepted access. This holds for a write during a running access and for a write on the same edge as the acceptance, where the previous value is used.
- R9: `req_valid` while `ready` is low is ignored: no extra strobe follows once the access ends.
- R10: The two strobes are never high together, and `ready` is low whenever a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timing unit per period |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load a timing word |
| cfg_drive | input | 1 | Drive whose timing word is loaded |
| cfg_word | input | 16 | Timing word value |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_drive | input | 1 | Drive targeted by the access |
| iordy | input | 1 | Device ready; low stretches the active phase |
| rd_strobe | output | 1 | Active-high read command strobe |
| wr_strobe | output | 1 | Active-high write command strobe |
| ready | output | 1 | High only when idle and able to accept |
| done | output | 1 | One-cycle pulse when recovery ends |

## Verification
On every cycle, the assertions check the following:
- the strobes are mutually exclusive and imply a busy channel;
- an accepted request raises the correct strobe;
- a falling strobe is followed by at least one recovery cycle;
- `done` is a single pulse coinciding with `ready`;
- an idle channel stays idle without a request.

The exact phase lengths for each word value, the IORDY stretch, the ignored bits, per-drive selection and the deferred effect of rewrites depend on programmed values. Only the bench's scenarios, which measure strobe and recovery widths at the ports, can show them.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACTIVE  = 2'd1,
    PH_RECOVER = 2'd2
  } phase_e;
endpackage

// File: rtl/ata_timing_regs.sv
// Per-drive timing storage. Only the fields that matter are kept.
module ata_timing_regs #(
  parameter int NUM_DRIVES = 2,
  parameter int SEL_W      = 1,
  parameter int ACT_W      = 4,
  parameter int REC_W      = 6,
  parameter int ENT_W      = ACT_W + 1 + REC_W,
  parameter logic [ENT_W-1:0] RESET_ENT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [ENT_W-1:0] rd_ent
);
  logic [ENT_W-1:0] ent_q [NUM_DRIVES];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q[d] <= RESET_ENT;
      end else if (wr_en && (wr_sel == SEL_W'(d))) begin
        ent_q[d] <= wr_ent;
      end
    end
  end

  assign rd_ent = ent_q[rd_sel];
endmodule

// File: rtl/ata_phase_ctrl.sv
// Active / recovery sequencer with IORDY stretch.
module ata_phase_ctrl
  import ata_strobe_pkg::*;
#(
  parameter int ACT_W = 4,
  parameter int REC_W = 6,
  parameter int CNT_W = (ACT_W > REC_W) ? ACT_W : REC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ACT_W-1:0] act_m1,
  input  logic [REC_W-1:0] rec_m1,
  input  logic             iordy_en,
  input  logic             iordy,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic             ready,
  output logic             done
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REC_W-1:0] rec_q;
  logic             ien_q;
  logic             rd_q, wr_q, ready_q, done_q;
  logic             stall;

  // Hold the active phase while the device reports not ready.
  assign stall = ien_q && !iordy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      ien_q   <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            phase_q <= PH_ACTIVE;
            cnt_q   <= CNT_W'(act_m1);
            rec_q   <= rec_m1;
            ien_q   <= iordy_en;
            rd_q    <= !req_write;
            wr_q    <= req_write;
            ready_q <= 1'b0;
          end
        end
        PH_ACTIVE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!stall) begin
            phase_q <= PH_RECOVER;
            cnt_q   <= CNT_W'(rec_q);
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
          end
        end
        PH_RECOVER: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            phase_q <= PH_IDLE;
            ready_q <= 1'b1;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign rd_strobe = rd_q;
  assign wr_strobe = wr_q;
  assign ready     = ready_q;
  assign done      = done_q;
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen #(
  parameter int NUM_DRIVES = 2,
  parameter int SEL_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  parameter int WORD_W     = 16,
  parameter int ACT_LSB    = 8,
  parameter int ACT_W      = 4,
  parameter int REC_W      = 6,
  parameter int IORDY_BIT  = 6,
  parameter logic [WORD_W-1:0] RESET_WORD = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_drive,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_drive,
  input  logic              iordy,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              ready,
  output logic              done
);
  localparam int ENT_W = ACT_W + 1 + REC_W;

  function automatic logic [ENT_W-1:0] pack_word(input logic [WORD_W-1:0] w);
    return {w[ACT_LSB +: ACT_W], w[IORDY_BIT], w[REC_W-1:0]};
  endfunction

  localparam logic [ENT_W-1:0] RESET_ENT = pack_word(RESET_WORD);

  logic [ENT_W-1:0] sel_ent;

  ata_timing_regs #(
    .NUM_DRIVES(NUM_DRIVES), .SEL_W(SEL_W), .ACT_W(ACT_W), .REC_W(REC_W),
    .ENT_W(ENT_W), .RESET_ENT(RESET_ENT)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_sel (cfg_drive),
    .wr_ent (pack_word(cfg_word)),
    .rd_sel (req_drive),
    .rd_ent (sel_ent)
  );

  ata_phase_ctrl #(.ACT_W(ACT_W), .REC_W(REC_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .act_m1    (sel_ent[ENT_W-1 -: ACT_W]),
    .rec_m1    (sel_ent[REC_W-1:0]),
    .iordy_en  (sel_ent[REC_W]),
    .iordy     (iordy),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .ready     (ready),
    .done      (done)
  );
endmodule

// File: rtl/ata_strobe_chk.sv
module ata_strobe_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_write,
  input logic rd_strobe,
  input logic wr_strobe,
  input logic ready,
  input logic done
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && !rd_strobe && !wr_strobe && !done));

  p_wr_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && req_write) |=> (wr_strobe && !rd_strobe));

  p_rd_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && !req_write) |=> (rd_strobe && !wr_strobe));

  p_recover_after_rd_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_strobe) |-> !ready);

  p_recover_after_wr_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_strobe) |-> !ready);

  p_done_with_ready_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (ready && $rose(ready)));

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && !req_valid) |=> ready);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe));

  p_busy_when_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || wr_strobe) |-> !ready);
endmodule

bind ata_strobe_gen ata_strobe_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .rd_strobe (rd_strobe),
  .wr_strobe (wr_strobe),
  .ready     (ready),
  .done      (done)
);

// File: tb/test_ata_strobe_gen.sv
`timescale 1ns/1ps
module test_ata_strobe_gen;
  logic clk = 1'b0;
  logic rst, cfg_we, cfg_drive, req_valid, req_write, req_drive, iordy;
  logic [15:0] cfg_word;
  logic rd_strobe, wr_strobe, ready, done;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ata_strobe_gen i_ata_strobe_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_drive(cfg_drive), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_write(req_write), .req_drive(req_drive), .iordy(iordy),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .ready(ready), .done(done)
  );

  // {word[15:0], drive, write, iordy release count[7:0]}; release 0 = high throughout
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {16'h0707, 1'b0, 1'b0, 8'd0},
    {16'h0201, 1'b1, 1'b1, 8'd0},
    {16'h0200, 1'b0, 1'b1, 8'd0},
    {16'h0000, 1'b1, 1'b0, 8'd0},
    {16'h0340, 1'b0, 1'b0, 8'd7},
    {16'h0340, 1'b1, 1'b1, 8'd2},
    {16'h0300, 1'b0, 1'b0, 8'd6},
    {16'hF0BF, 1'b1, 1'b1, 8'd0},
    {16'h0F45, 1'b0, 1'b0, 8'd20}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_word(input logic drv, input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_drive = drv; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issue one access and measure strobe and recovery widths at the ports.
  task automatic run_access(input logic drv, input logic wr, input int hold,
                            output int a_len, output int r_len,
                            output bit done_ok, output bit other_seen);
    a_len = 0; r_len = 0; other_seen = 0;
    @(negedge clk);
    iordy = (hold == 0);
    req_valid = 1'b1; req_write = wr; req_drive = drv;
    @(negedge clk);
    req_valid = 1'b0;
    while ((wr ? wr_strobe : rd_strobe) && a_len < 500) begin
      if (wr ? rd_strobe : wr_strobe) other_seen = 1;
      a_len++;
      if (a_len == hold) iordy = 1'b1;
      @(negedge clk);
    end
    iordy = 1'b1;
    while (!ready && !rd_strobe && !wr_strobe && r_len < 500) begin
      r_len++;
      @(negedge clk);
    end
    done_ok = done && ready;
    @(negedge clk);
    done_ok = done_ok && !done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a, r, ea, er;
    bit dk, oth;
    rst = 1'b1; cfg_we = 0; cfg_drive = 0; cfg_word = 0;
    req_valid = 0; req_write = 0; req_drive = 0; iordy = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(ready && !rd_strobe && !wr_strobe && !done, "R1 idle outputs", {ready, rd_strobe, wr_strobe, done}, 4'b1000);
    // R1: reset word gives 16 / 64
    run_access(1'b1, 1'b0, 0, a, r, dk, oth);
    check(a == 16, "R1 reset active", a, 16);
    check(r == 64, "R1 reset recovery", r, 64);

    // Vector walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      logic [15:0] w;
      logic d, wrb;
      int h;
      w = VEC[i][25:10]; d = VEC[i][9]; wrb = VEC[i][8]; h = int'(VEC[i][7:0]);
      ea = int'(w[11:8]) + 1;
      er = int'(w[5:0]) + 1;
      if (w[6] && h > ea) ea = h;
      load_word(d, w);
      run_access(d, wrb, h, a, r, dk, oth);
      check(a == ea, $sformatf("R2/R4/R5/R7 vec%0d active", i), a, ea);
      check(r == er, $sformatf("R3/R7 vec%0d recovery", i), r, er);
      check(dk, $sformatf("R3 vec%0d done pulse", i), dk, 1);
      check(!oth, $sformatf("R10 vec%0d other strobe", i), oth, 0);
    end

    // R6: independent per-drive words
    load_word(1'b0, 16'h0300);
    load_word(1'b1, 16'h0001);
    run_access(1'b0, 1'b1, 0, a, r, dk, oth);
    check(a == 4 && r == 1, "R6 drive0 word", a * 100 + r, 401);
    run_access(1'b1, 1'b1, 0, a, r, dk, oth);
    check(a == 1 && r == 2, "R6 drive1 word", a * 100 + r, 102);

    // R8: rewrite during a running access
    load_word(1'b0, 16'h0505);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_drive = 0;
    @(negedge clk);
    req_valid = 0; cfg_we = 1; cfg_drive = 0; cfg_word = 16'h0000;
    a = 1;
    @(negedge clk);
    cfg_we = 0;
    while (rd_strobe && a < 500) begin a++; @(negedge clk); end
    r = 0;
    while (!ready && r < 500) begin r++; @(negedge clk); end
    check(a == 6 && r == 6, "R8 running access unchanged", a * 100 + r, 606);
    run_access(1'b0, 1'b0, 0, a, r, dk, oth);
    check(a == 1 && r == 1, "R8 next access uses new word", a * 100 + r, 101);

    // R8: write on the accepting edge uses the old word
    load_word(1'b1, 16'h0202);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_drive = 1;
    cfg_we = 1; cfg_drive = 1; cfg_word = 16'h0000;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    a = 0;
    while (wr_strobe && a < 500) begin a++; @(negedge clk); end
    check(a == 3, "R8 same-edge write deferred", a, 3);
    while (!ready) @(negedge clk);

    // R9: request while busy is ignored
    load_word(1'b0, 16'h0101);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_drive = 0;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!ready) @(negedge clk);
    oth = 0;
    repeat (6) begin
      @(negedge clk);
      if (rd_strobe || wr_strobe || !ready) oth = 1;
    end
    check(!oth, "R9 busy request dropped", oth, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule